// File: doc/BRIEF.md
# Cascade Link for Chained Content-Addressable Memories

This block sits in each device of a chain of identical content-addressable memories that together act as one large search memory. It takes the local search results from its own array (hit, multiple hit, match address, free-slot status and the first free address) and combines them with the hit and full signals from the device above it in the chain. It produces the hit and full signals it passes to the device below. The last device in the chain presents the system-wide hit and full flags.

The same block decides whether its device may drive the shared data bus on a read. Only the device that owns the answer drives it: the topmost device with a hit for a match-address read, and the topmost device with a free slot for a free-address read. A device must also be selected, either because its programmed page number equals the device-select value or because that value is all ones (broadcast). Every word it returns carries the low page bits as a tag above the address, so the host can tell which device answered.

Top module: `cam_chain_node`

## Requirements
- R1: `dn_hit_n` is low exactly when the latched chain enable is active and either `arr_hit` is 1 or `up_hit_n` is low.
- R2: `chain_en_n` is sampled only on a rising clock edge with `cyc_start` high (low means enabled). Between such edges the latched enable holds, and while it is inactive `dn_hit_n` stays high.
- R3: `dn_full_n` is low exactly when `up_full_n` is low and `arr_has_free` is 0. The first device has `up_full_n` tied low.
- R4: `loc_hit_n` equals the inverse of `arr_hit` and `loc_multi_n` equals the inverse of `arr_multi`, regardless of chain enable, `up_hit_n` and `up_full_n`.
- R5: A match read (`rd_req`=1, `rd_kind`=0) sets `bus_oe` only when the device is selected, `arr_hit` is 1 and `up_hit_n` is high. `bus_dout` then equals page bits [4:0] in bits 15:11 and `arr_hit_addr` in bits 10:0.
- R6: A match read with `arr_hit` at 0 leaves `bus_oe` low, so no device drives the bus when the chain has no hit.
- R7: A free-address read (`rd_req`=1, `rd_kind`=1) sets `bus_oe` only when the device is selected, `up_full_n` is low and `arr_has_free` is 1. `bus_dout` then equals page bits [4:0] in bits 15:11 and `arr_free_addr` in bits 10:0.
- R8: `page_wr` loads the page register from `wr_data` and `sel_wr` loads the device-select register, each on the next clock edge. `dev_sel` is 1 when device-select equals page, or when device-select is 16'hFFFF.
- R9: A clock edge with `rst_n` low clears page, device-select and the latched chain enable.
- R10: A clock edge with `soft_clr` high clears the latched chain enable and leaves page and device-select unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| soft_clr | input | 1 | Software clear; keeps page and device-select |
| cyc_start | input | 1 | Marks the first cycle of a bus access |
| chain_en_n | input | 1 | Chain enable, active low, sampled with cyc_start |
| up_hit_n | input | 1 | Hit from higher-priority device, active low |
| up_full_n | input | 1 | Full from higher-priority device, active low |
| arr_hit | input | 1 | Local array has at least one hit |
| arr_multi | input | 1 | Local array has more than one hit |
| arr_hit_addr | input | 11 | Local highest-priority hit address |
| arr_has_free | input | 1 | Local array has an empty slot |
| arr_free_addr | input | 11 | Local first empty address |
| page_wr | input | 1 | Load page register |
| sel_wr | input | 1 | Load device-select register |
| wr_data | input | 16 | Data for page or device-select load |
| rd_req | input | 1 | Read request |
| rd_kind | input | 1 | 0 = match address, 1 = free address |
| dn_hit_n | output | 1 | Chained hit to next device, active low |
| dn_full_n | output | 1 | Chained full to next device, active low |
| loc_hit_n | output | 1 | Unqualified local hit, active low |
| loc_multi_n | output | 1 | Unqualified local multiple hit, active low |
| dev_sel | output | 1 | Device is selected |
| bus_oe | output | 1 | Device drives the shared bus |
| bus_dout | output | 16 | Data for the shared bus |

## Verification
The bench goes after devices that wrongly claim the bus. One case is a device with a local hit while a higher device also hits; a design that ignored `up_hit_n` would put two drivers on the bus. It also checks that the chain enable is held between cycle starts and cleared by a software clear; a design that sampled it every edge or kept it across the clear would pass a stale hit downstream. Device-select checks cover a mismatch, broadcast, and page retention across a software clear. A design that lost the page on that clear would return a wrong tag in `bus_dout`.

// File: rtl/cam_chain_pkg.sv
// Shared types for the cascade link.
// Assumes: read kinds are encoded on a single bit at the top ports.
package cam_chain_pkg;
    typedef enum logic {
        RD_MATCH = 1'b0,
        RD_FREE  = 1'b1
    } rd_kind_e;

    localparam logic [15:0] BCAST_SEL = 16'hFFFF;
endpackage

// File: rtl/chain_flags.sv
// Chain flag logic: latches the chain enable at the start of each access
// and combines local hit and free status with the upstream chain inputs.
// Assumes: chain inputs are active low; the flag ripple settles within a cycle.
module chain_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_clr,
    input  logic cyc_start,
    input  logic chain_en_n,
    input  logic up_hit_n,
    input  logic up_full_n,
    input  logic arr_hit,
    input  logic arr_has_free,
    output logic dn_hit_n,
    output logic dn_full_n
);
    logic en_q;

    // Capture the chain enable only when an access begins.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr)
            en_q <= 1'b0;
        else if (cyc_start)
            en_q <= ~chain_en_n;
    end

    // Pass a hit downstream when enabled and any device up to here hits.
    always_comb dn_hit_n = ~(en_q & (arr_hit | ~up_hit_n));

    // The device reports full only when all devices above and itself are full.
    always_comb dn_full_n = up_full_n | arr_has_free;

    assert_en_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_start && !soft_clr) |=> $stable(en_q));

    assert_quiet_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> dn_hit_n);

    assert_full_rule_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !dn_full_n |-> (!up_full_n && !arr_has_free));
endmodule

// File: rtl/dev_select.sv
// Device selection: holds the page number and device-select value and
// flags the device as selected on equality or broadcast.
// Assumes: only a hardware reset clears these registers.
module dev_select #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_wr,
    input  logic              sel_wr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] page_q,
    output logic              dev_sel
);
    import cam_chain_pkg::*;

    logic [DATA_W-1:0] sel_q;

    // Page register, loaded by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)
            page_q <= '0;
        else if (page_wr)
            page_q <= wr_data;
    end

    // Device-select register, loaded by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (sel_wr)
            sel_q <= wr_data;
    end

    // Selected on matching page or on broadcast value.
    always_comb dev_sel = (sel_q == page_q) || (sel_q == BCAST_SEL[DATA_W-1:0]);

    assert_bcast_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && wr_data == BCAST_SEL[DATA_W-1:0]) |=> dev_sel);
endmodule

// File: rtl/bus_arbiter.sv
// Bus ownership: lets the device drive the shared bus only when it is
// selected and is the highest-priority owner of the requested result.
// Assumes: upstream hit and full inputs reflect all higher devices.
module bus_arbiter #(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned DATA_W = 16,
    localparam int unsigned TAG_W = DATA_W - ADDR_W
) (
    input  logic              dev_sel,
    input  logic              rd_req,
    input  logic              rd_kind,
    input  logic              up_hit_n,
    input  logic              up_full_n,
    input  logic              arr_hit,
    input  logic              arr_has_free,
    input  logic [ADDR_W-1:0] arr_hit_addr,
    input  logic [ADDR_W-1:0] arr_free_addr,
    input  logic [TAG_W-1:0]  page_tag,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_dout
);
    import cam_chain_pkg::*;

    rd_kind_e kind;
    logic     own_match;
    logic     own_free;

    // Decode the read kind and work out which results this device owns.
    always_comb begin
        kind      = rd_kind_e'(rd_kind);
        own_match = arr_hit & up_hit_n;
        own_free  = arr_has_free & ~up_full_n;
    end

    // Drive enable and tagged data for the owned result.
    always_comb begin
        bus_oe   = 1'b0;
        bus_dout = '0;
        if (kind == RD_MATCH) begin
            bus_oe   = rd_req & dev_sel & own_match;
            bus_dout = {page_tag, arr_hit_addr};
        end else begin
            bus_oe   = rd_req & dev_sel & own_free;
            bus_dout = {page_tag, arr_free_addr};
        end
    end

    always_comb begin
        if (bus_oe && kind == RD_MATCH)
            assert_match_owner_R5: assert (arr_hit && up_hit_n && dev_sel);
        if (bus_oe && kind == RD_FREE)
            assert_free_owner_R7: assert (arr_has_free && !up_full_n && dev_sel);
    end
endmodule

// File: rtl/cam_chain_node.sv
// Cascade link top: chain flags, device selection and bus ownership
// for one device in a chain of search memories.
// Assumes: ADDR_W < DATA_W so the page tag has at least one bit.
module cam_chain_node #(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned DATA_W = 16,
    localparam int unsigned TAG_W = DATA_W - ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              cyc_start,
    input  logic              chain_en_n,
    input  logic              up_hit_n,
    input  logic              up_full_n,
    input  logic              arr_hit,
    input  logic              arr_multi,
    input  logic [ADDR_W-1:0] arr_hit_addr,
    input  logic              arr_has_free,
    input  logic [ADDR_W-1:0] arr_free_addr,
    input  logic              page_wr,
    input  logic              sel_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_req,
    input  logic              rd_kind,
    output logic              dn_hit_n,
    output logic              dn_full_n,
    output logic              loc_hit_n,
    output logic              loc_multi_n,
    output logic              dev_sel,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_dout
);
    logic [DATA_W-1:0] page_q;

    chain_flags u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .soft_clr     (soft_clr),
        .cyc_start    (cyc_start),
        .chain_en_n   (chain_en_n),
        .up_hit_n     (up_hit_n),
        .up_full_n    (up_full_n),
        .arr_hit      (arr_hit),
        .arr_has_free (arr_has_free),
        .dn_hit_n     (dn_hit_n),
        .dn_full_n    (dn_full_n)
    );

    dev_select #(.DATA_W(DATA_W)) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .page_wr (page_wr),
        .sel_wr  (sel_wr),
        .wr_data (wr_data),
        .page_q  (page_q),
        .dev_sel (dev_sel)
    );

    bus_arbiter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arb (
        .dev_sel       (dev_sel),
        .rd_req        (rd_req),
        .rd_kind       (rd_kind),
        .up_hit_n      (up_hit_n),
        .up_full_n     (up_full_n),
        .arr_hit       (arr_hit),
        .arr_has_free  (arr_has_free),
        .arr_hit_addr  (arr_hit_addr),
        .arr_free_addr (arr_free_addr),
        .page_tag      (page_q[TAG_W-1:0]),
        .bus_oe        (bus_oe),
        .bus_dout      (bus_dout)
    );

    // Local flags are reported without any chain qualification.
    always_comb begin
        loc_hit_n   = ~arr_hit;
        loc_multi_n = ~arr_multi;
    end

    assert_no_hit_no_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_kind && !arr_hit) |-> !bus_oe);

    assert_multi_implies_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_multi && arr_hit) |-> (!loc_multi_n && !loc_hit_n));

    assert_soft_keeps_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_clr && !page_wr && !sel_wr) |=> $stable(dev_sel));

    assert_hit_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!dn_hit_n) |-> (arr_hit || !up_hit_n));
endmodule

// File: tb/sim_cam_chain_node.sv
module sim_cam_chain_node;
    localparam int CLK_P = 10;
    localparam int NV    = 8;

    logic        clk = 1'b0;
    logic        rst_n, soft_clr, cyc_start, chain_en_n, up_hit_n, up_full_n;
    logic        arr_hit, arr_multi, arr_has_free, page_wr, sel_wr, rd_req, rd_kind;
    logic [10:0] arr_hit_addr, arr_free_addr;
    logic [15:0] wr_data;
    logic        dn_hit_n, dn_full_n, loc_hit_n, loc_multi_n, dev_sel, bus_oe;
    logic [15:0] bus_dout;

    int total = 0;
    int bad   = 0;

    // Vector: en_n uh_n uf_n hit multi free req kind | dh_n df_n lh_n lm_n oe
    localparam logic [12:0] VEC [NV] = '{
        13'b0_1_1_1_0_1_1_0__0_1_0_1_1,
        13'b0_0_1_1_1_1_1_0__0_1_0_0_0,
        13'b1_1_0_1_0_0_1_0__1_0_0_1_1,
        13'b0_1_1_0_0_1_1_0__1_1_1_1_0,
        13'b0_0_0_0_0_1_1_1__0_1_1_1_1,
        13'b0_1_1_0_0_1_1_1__1_1_1_1_0,
        13'b0_1_0_0_0_0_1_1__1_0_1_1_0,
        13'b0_1_1_1_0_0_0_0__0_1_0_1_0
    };

    cam_chain_node u0 (.*);

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Start an access with the given chain enable, then return at the next negedge.
    task automatic start_cyc(input logic en_n);
        chain_en_n = en_n;
        cyc_start  = 1'b1;
        tick();
        cyc_start  = 1'b0;
    endtask

    initial begin
        #(CLK_P * 100000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 0; soft_clr = 0; cyc_start = 0; chain_en_n = 1;
        up_hit_n = 1; up_full_n = 1; arr_hit = 1; arr_multi = 0; arr_has_free = 1;
        arr_hit_addr = 11'h2A5; arr_free_addr = 11'h123;
        page_wr = 0; sel_wr = 0; wr_data = 0; rd_req = 0; rd_kind = 0;
        @(negedge clk);
        tick();
        rst_n = 1;
        tick();
        // R9: reset state, chain disabled, page and select both zero so selected
        chk("R9 dn_hit_n after reset", 16'(dn_hit_n), 16'h1);
        chk("R9 dev_sel after reset", 16'(dev_sel), 16'h1);
        rd_req = 1;
        @(negedge clk);
        chk("R9 page tag zero", bus_dout, {5'h00, 11'h2A5});
        rd_req = 0;

        // R8: program page and matching select
        page_wr = 1; wr_data = 16'h0013; tick(); page_wr = 0;
        chk("R8 page differs from select", 16'(dev_sel), 16'h0);
        sel_wr = 1; wr_data = 16'h0013; tick(); sel_wr = 0;
        chk("R8 select equals page", 16'(dev_sel), 16'h1);

        // Table walk: R1 R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            logic [12:0] v;
            v = VEC[i];
            up_hit_n = v[11]; up_full_n = v[10]; arr_hit = v[9];
            arr_multi = v[8]; arr_has_free = v[7]; rd_req = v[6]; rd_kind = v[5];
            start_cyc(v[12]);
            chk($sformatf("R1 dn_hit_n vec%0d", i), 16'(dn_hit_n), 16'(v[4]));
            chk($sformatf("R3 dn_full_n vec%0d", i), 16'(dn_full_n), 16'(v[3]));
            chk($sformatf("R4 loc flags vec%0d", i), {14'd0, loc_hit_n, loc_multi_n}, {14'd0, v[2], v[1]});
            chk($sformatf("R5 R6 R7 bus_oe vec%0d", i), 16'(bus_oe), 16'(v[0]));
            if (v[0])
                chk($sformatf("R5 R7 bus_dout vec%0d", i), bus_dout,
                    v[5] ? {5'h13, 11'h123} : {5'h13, 11'h2A5});
        end

        // R2: enable held without cyc_start, released at the next start
        up_hit_n = 1; arr_hit = 1; rd_req = 0;
        start_cyc(1'b0);
        chain_en_n = 1'b1; tick();
        chk("R2 enable held", 16'(dn_hit_n), 16'h0);
        start_cyc(1'b1);
        chk("R2 disabled at start", 16'(dn_hit_n), 16'h1);

        // R8: mismatch blocks a read, broadcast restores it
        sel_wr = 1; wr_data = 16'h0007; tick(); sel_wr = 0;
        rd_req = 1; rd_kind = 0; arr_hit = 1; up_hit_n = 1;
        @(negedge clk);
        chk("R8 unselected no drive", 16'(bus_oe), 16'h0);
        rd_req = 0;
        sel_wr = 1; wr_data = 16'hFFFF; tick(); sel_wr = 0;
        chk("R8 broadcast selects", 16'(dev_sel), 16'h1);

        // R10: soft clear drops enable, keeps page and select
        start_cyc(1'b0);
        chk("R10 enabled before clear", 16'(dn_hit_n), 16'h0);
        soft_clr = 1; tick(); soft_clr = 0;
        chk("R10 enable cleared", 16'(dn_hit_n), 16'h1);
        chk("R10 select kept", 16'(dev_sel), 16'h1);
        rd_req = 1;
        @(negedge clk);
        chk("R10 page tag kept", bus_dout, {5'h13, 11'h2A5});
        rd_req = 0;

        // R9: hardware reset clears page and select
        rst_n = 0; tick(); rst_n = 1;
        rd_req = 1;
        @(negedge clk);
        chk("R9 page cleared", bus_dout, {5'h00, 11'h2A5});
        chk("R9 select equals cleared page", 16'(dev_sel), 16'h1);
        rd_req = 0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule